// File: doc/BRIEF.md
# Mailbox Sender Window Bank

This block is the transmit half of a processor-to-processor mailbox. The sending processor raises bits in a set of 32-bit windows through write-one-to-set registers. The window contents go to a paired receiver, which consumes a message by clearing bits through a dedicated clear port. The sender reads each window's status back as the receiver currently leaves it. A transfer on a window is complete when that window's status has drained to zero.

When the hardware revision supports it, each window latches a completion flag at the moment the receiver drains it. The flag gates a combined interrupt through a per-window enable. A frame-level access request goes out to the receiver. The receiver's ready indication comes back through a two-stage synchronizer. Its rising and falling edges are reported as frame interrupt events.

Windows sit at a 0x20-byte stride from address 0. Per-window offsets: status 0x00 (read only), set 0x0C, completion flag 0x10, flag clear 0x14, flag enable 0x18. The frame block starts at NUM_WIN*0x20. Frame offsets: configuration +0x00, access request +0x08, access ready +0x0C, frame event status +0x10, event clear +0x14, event enable +0x18, combined pending +0x20, identification +0x24.

Top module: `mbx_sender`

## Requirements
- R1: After reset every window status, completion flag and enable is zero, the access request and ready are zero, all frame events and enables are zero, and irq_o is low.
- R2: Writing to a window's set offset 0x0C ORs the written value into that window's status. Zero bits leave status bits unchanged. The status reads back at offset 0x00 and appears on the window's slice of win_stat_o at the clock edge of the write.
- R3: A receiver clear (rcv_clr_en with a window index and bit mask) clears the masked bits of that window at the next edge. When a sender set and a receiver clear hit the same bit in the same cycle, the set wins.
- R4: A window's completion flag (bit 0 at offset 0x10) sets on the edge where its status goes from nonzero to zero. A partial clear that leaves bits standing does not set it. The flag holds until a 1 is written to bit 0 of offset 0x14. A new drain in the same cycle as that clear leaves the flag set.
- R5: Bit 0 of window offset 0x18 enables that window's flag. In the combined pending register (frame +0x20), bit i reads as window i's flag AND its enable.
- R6: irq_o is high when frame enable bit 2 is set and any combined pending bit is set, or when an enabled frame event is pending (R8).
- R7: Bit 0 of frame +0x08 drives acc_req_o. Bit 0 of frame +0x0C shows rx_ready_i delayed by exactly two clock edges.
- R8: Frame event status bit 0 (+0x10) sets on a rising edge of the synchronized ready and bit 1 on a falling edge. Each clears by writing 1 to the same bit at +0x14. In the enable register (+0x18), bit 1 gates status bit 0 and bit 0 gates status bit 1.
- R9: The configuration register reads NUM_WIN in bits [6:0]. The identification register reads the minor revision in bits [3:0] and the major revision in bits [7:4].
- R10: With a minor revision of 0, completion flags never set and irq_o stays low on window drains.
- R11: Writes to a window's status offset 0x00 are ignored: the status is unchanged afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | AW | Write byte address |
| reg_wr_data | input | DW | Write data |
| reg_rd_addr | input | AW | Read byte address |
| reg_rd_data | output | DW | Read data, combinational from reg_rd_addr |
| rcv_clr_en | input | 1 | Receiver clear strobe |
| rcv_clr_win | input | WIN_IW | Window index of the receiver clear |
| rcv_clr_mask | input | DW | Bits the receiver clears |
| win_stat_o | output | NUM_WIN*DW | All window status words to the receiver, window 0 in the low bits |
| acc_req_o | output | 1 | Frame access request to the receiver |
| rx_ready_i | input | 1 | Receiver ready, asynchronous |
| irq_o | output | 1 | Combined interrupt |

## Verification
Writes and receiver clears are presented half a cycle before a rising edge. Their effect on status, completion flags, frame events and irq_o is due at that same edge. The bench therefore reads the combinational read port at the following falling edge. The access-ready bit is due two edges after rx_ready_i changes. The bench checks that it is still unchanged one falling edge after the input moves, and changed at the second. A frame event is due on the same edge as the ready change.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int WIN_STRIDE = 32;
    localparam int FRAME_SPAN = 64;

    localparam logic [4:0] WOFF_STAT = 5'h00;
    localparam logic [4:0] WOFF_SET  = 5'h0C;
    localparam logic [4:0] WOFF_FLAG = 5'h10;
    localparam logic [4:0] WOFF_FCLR = 5'h14;
    localparam logic [4:0] WOFF_FEN  = 5'h18;

    localparam logic [5:0] FOFF_CFG  = 6'h00;
    localparam logic [5:0] FOFF_REQ  = 6'h08;
    localparam logic [5:0] FOFF_RDY  = 6'h0C;
    localparam logic [5:0] FOFF_EVT  = 6'h10;
    localparam logic [5:0] FOFF_ECLR = 6'h14;
    localparam logic [5:0] FOFF_EEN  = 6'h18;
    localparam logic [5:0] FOFF_COMB = 6'h20;
    localparam logic [5:0] FOFF_ID   = 6'h24;

    typedef struct packed {
        logic       req;
        logic       sync1;
        logic       rdy;
        logic [1:0] evt;
        logic [2:0] een;
    } frame_state_t;
endpackage

// File: rtl/mbx_win.sv
module mbx_win #(
    parameter int DW        = 32,
    parameter int MINOR_REV = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_we,
    input  logic [DW-1:0] set_data,
    input  logic          fclr_we,
    input  logic          fclr_bit,
    input  logic          fen_we,
    input  logic          fen_bit,
    input  logic          rcv_clr,
    input  logic [DW-1:0] rcv_mask,
    output logic [DW-1:0] stat,
    output logic          flag,
    output logic          flag_en
);
    localparam bit HAS_IRQ = (MINOR_REV != 0);

    typedef struct packed {
        logic [DW-1:0] stat;
        logic          flag;
        logic          en;
    } win_state_t;

    win_state_t st_d, st_q;
    logic drained;

    always_comb begin
        st_d = st_q;
        st_d.stat = (st_q.stat & ~(rcv_clr ? rcv_mask : '0))
                  | (set_we ? set_data : '0);
        drained = (st_q.stat != '0) && (st_d.stat == '0);
        if (fclr_we && fclr_bit) st_d.flag = 1'b0;
        if (fen_we) st_d.en = fen_bit;
        if (drained) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat    = st_q.stat;
    assign flag_en = st_q.en;

    generate
        if (HAS_IRQ) begin : g_flag
            assign flag = st_q.flag;
        end else begin : g_noflag
            assign flag = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/mbx_frame.sv
module mbx_frame
    import mbx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_we,
    input  logic       req_bit,
    input  logic       eclr_we,
    input  logic [1:0] eclr_bits,
    input  logic       een_we,
    input  logic [2:0] een_bits,
    input  logic       rx_ready_i,
    input  logic       win_pend,
    output logic       acc_req,
    output logic       acc_ready,
    output logic [1:0] evt,
    output logic [2:0] een,
    output logic       irq
);
    frame_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (req_we) st_d.req = req_bit;
        st_d.sync1 = rx_ready_i;
        st_d.rdy   = st_q.sync1;
        if (eclr_we) st_d.evt = st_q.evt & ~eclr_bits;
        if (st_d.rdy && !st_q.rdy) st_d.evt[0] = 1'b1;
        if (!st_d.rdy && st_q.rdy) st_d.evt[1] = 1'b1;
        if (een_we) st_d.een = een_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_req   = st_q.req;
    assign acc_ready = st_q.rdy;
    assign evt       = st_q.evt;
    assign een       = st_q.een;
    assign irq       = (st_q.een[2] && win_pend)
                     || (st_q.evt[0] && st_q.een[1])
                     || (st_q.evt[1] && st_q.een[0]);
endmodule

// File: rtl/mbx_sender.sv
module mbx_sender
    import mbx_pkg::*;
#(
    parameter int NUM_WIN   = 4,
    parameter int DW        = 32,
    parameter int AW        = 12,
    parameter int MAJOR_REV = 2,
    parameter int MINOR_REV = 1,
    parameter int WIN_IW    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr_en,
    input  logic [AW-1:0]         reg_wr_addr,
    input  logic [DW-1:0]         reg_wr_data,
    input  logic [AW-1:0]         reg_rd_addr,
    output logic [DW-1:0]         reg_rd_data,
    input  logic                  rcv_clr_en,
    input  logic [WIN_IW-1:0]     rcv_clr_win,
    input  logic [DW-1:0]         rcv_clr_mask,
    output logic [NUM_WIN*DW-1:0] win_stat_o,
    output logic                  acc_req_o,
    input  logic                  rx_ready_i,
    output logic                  irq_o
);
    localparam int FRAME_BASE = NUM_WIN * WIN_STRIDE;
    localparam int WSEL_W     = AW - 5;

    logic [DW-1:0]      win_stat [NUM_WIN];
    logic [NUM_WIN-1:0] win_flag, win_fen, comb_pend;
    logic               acc_ready;
    logic [1:0]         frm_evt;
    logic [2:0]         frm_een;

    logic [AW-1:0] wr_rel, rd_rel;
    logic          wr_frame, rd_frame;
    logic [5:0]    wr_foff, rd_foff;

    assign wr_rel   = reg_wr_addr - AW'(FRAME_BASE);
    assign rd_rel   = reg_rd_addr - AW'(FRAME_BASE);
    assign wr_frame = reg_wr_en && (reg_wr_addr >= AW'(FRAME_BASE))
                      && (wr_rel < AW'(FRAME_SPAN));
    assign rd_frame = (reg_rd_addr >= AW'(FRAME_BASE))
                      && (rd_rel < AW'(FRAME_SPAN));
    assign wr_foff  = wr_rel[5:0];
    assign rd_foff  = rd_rel[5:0];

    genvar gi;
    generate
        for (gi = 0; gi < NUM_WIN; gi++) begin : g_win
            logic hit;
            assign hit = reg_wr_en && (reg_wr_addr[AW-1:5] == WSEL_W'(gi));

            mbx_win #(.DW(DW), .MINOR_REV(MINOR_REV)) u_win (
                .clk      (clk),
                .rst_n    (rst_n),
                .set_we   (hit && reg_wr_addr[4:0] == WOFF_SET),
                .set_data (reg_wr_data),
                .fclr_we  (hit && reg_wr_addr[4:0] == WOFF_FCLR),
                .fclr_bit (reg_wr_data[0]),
                .fen_we   (hit && reg_wr_addr[4:0] == WOFF_FEN),
                .fen_bit  (reg_wr_data[0]),
                .rcv_clr  (rcv_clr_en && rcv_clr_win == WIN_IW'(gi)),
                .rcv_mask (rcv_clr_mask),
                .stat     (win_stat[gi]),
                .flag     (win_flag[gi]),
                .flag_en  (win_fen[gi])
            );

            assign win_stat_o[gi*DW +: DW] = win_stat[gi];
        end
    endgenerate

    assign comb_pend = win_flag & win_fen;

    mbx_frame u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_we     (wr_frame && wr_foff == FOFF_REQ),
        .req_bit    (reg_wr_data[0]),
        .eclr_we    (wr_frame && wr_foff == FOFF_ECLR),
        .eclr_bits  (reg_wr_data[1:0]),
        .een_we     (wr_frame && wr_foff == FOFF_EEN),
        .een_bits   (reg_wr_data[2:0]),
        .rx_ready_i (rx_ready_i),
        .win_pend   (|comb_pend),
        .acc_req    (acc_req_o),
        .acc_ready  (acc_ready),
        .evt        (frm_evt),
        .een        (frm_een),
        .irq        (irq_o)
    );

    always_comb begin
        reg_rd_data = '0;
        if (rd_frame) begin
            unique case (rd_foff)
                FOFF_CFG:  reg_rd_data = DW'(NUM_WIN);
                FOFF_REQ:  reg_rd_data = DW'(acc_req_o);
                FOFF_RDY:  reg_rd_data = DW'(acc_ready);
                FOFF_EVT:  reg_rd_data = DW'(frm_evt);
                FOFF_EEN:  reg_rd_data = DW'(frm_een);
                FOFF_COMB: reg_rd_data = DW'(comb_pend);
                FOFF_ID:   reg_rd_data = DW'({4'(MAJOR_REV), 4'(MINOR_REV)});
                default:   reg_rd_data = '0;
            endcase
        end
        for (int i = 0; i < NUM_WIN; i++) begin
            if (reg_rd_addr[AW-1:5] == WSEL_W'(i)) begin
                unique case (reg_rd_addr[4:0])
                    WOFF_STAT: reg_rd_data = win_stat[i];
                    WOFF_FLAG: reg_rd_data = DW'(win_flag[i]);
                    WOFF_FEN:  reg_rd_data = DW'(win_fen[i]);
                    default:   reg_rd_data = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/mbx_sender_chk.sv
module mbx_sender_chk #(
    parameter int NUM_WIN = 4,
    parameter int DW      = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_wr_en,
    input logic                  rcv_clr_en,
    input logic                  rx_ready_i,
    input logic                  acc_ready,
    input logic                  irq_o,
    input logic [NUM_WIN*DW-1:0] win_stat_o,
    input logic [NUM_WIN-1:0]    win_flag,
    input logic [1:0]            frm_evt
);
    genvar gi;
    generate
        for (gi = 0; gi < NUM_WIN; gi++) begin : g_w
            AST_BITS_RISE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
                ((win_stat_o[gi*DW +: DW] & ~$past(win_stat_o[gi*DW +: DW])) != '0)
                |-> $past(reg_wr_en)); // R2
            AST_BITS_FALL_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                (($past(win_stat_o[gi*DW +: DW]) & ~win_stat_o[gi*DW +: DW]) != '0)
                |-> $past(rcv_clr_en)); // R3
            AST_FLAG_ON_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(win_flag[gi]) |-> (win_stat_o[gi*DW +: DW] == '0
                    && $past(win_stat_o[gi*DW +: DW]) != '0)); // R4
        end
    endgenerate

    AST_READY_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acc_ready) |-> $past(rx_ready_i, 2)); // R7
    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((|win_flag) || (|frm_evt))); // R6
endmodule

bind mbx_sender mbx_sender_chk #(.NUM_WIN(NUM_WIN), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr_en  (reg_wr_en),
    .rcv_clr_en (rcv_clr_en),
    .rx_ready_i (rx_ready_i),
    .acc_ready  (acc_ready),
    .irq_o      (irq_o),
    .win_stat_o (win_stat_o),
    .win_flag   (win_flag),
    .frm_evt    (frm_evt)
);

// File: tb/mbx_sender_test.sv
module mbx_sender_test;
    localparam int NW = 4;
    localparam int DW = 32;
    localparam int AW = 12;

    localparam logic [AW-1:0] W1_STAT = 12'h020, W1_SET = 12'h02C,
        W1_FLAG = 12'h030, W1_FCLR = 12'h034, W1_FEN = 12'h038;
    localparam logic [AW-1:0] F_CFG = 12'h080, F_REQ = 12'h088, F_RDY = 12'h08C,
        F_EVT = 12'h090, F_ECLR = 12'h094, F_EEN = 12'h098, F_COMB = 12'h0A0,
        F_ID = 12'h0A4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr_en = 1'b0;
    logic [AW-1:0] reg_wr_addr = '0, reg_rd_addr = '0;
    logic [DW-1:0] reg_wr_data = '0, reg_rd_data, rd_v0;
    logic rcv_clr_en = 1'b0;
    logic [1:0] rcv_clr_win = '0;
    logic [DW-1:0] rcv_clr_mask = '0;
    logic [NW*DW-1:0] win_stat_o, stat_v0;
    logic acc_req_o, irq_o, req_v0, irq_v0;
    logic rx_ready_i = 1'b0;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    mbx_sender uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .rcv_clr_en(rcv_clr_en), .rcv_clr_win(rcv_clr_win), .rcv_clr_mask(rcv_clr_mask),
        .win_stat_o(win_stat_o), .acc_req_o(acc_req_o), .rx_ready_i(rx_ready_i),
        .irq_o(irq_o));

    mbx_sender #(.MINOR_REV(0)) uut_v0 (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data), .reg_rd_addr(reg_rd_addr), .reg_rd_data(rd_v0),
        .rcv_clr_en(rcv_clr_en), .rcv_clr_win(rcv_clr_win), .rcv_clr_mask(rcv_clr_mask),
        .win_stat_o(stat_v0), .acc_req_o(req_v0), .rx_ready_i(rx_ready_i),
        .irq_o(irq_v0));

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Drive a write half a cycle before the edge; it lands at that edge.
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rclr(input logic [1:0] w, input logic [DW-1:0] m);
        @(negedge clk);
        rcv_clr_en = 1'b1; rcv_clr_win = w; rcv_clr_mask = m;
        @(negedge clk);
        rcv_clr_en = 1'b0;
    endtask

    // Combinational read at the current falling edge.
    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        reg_rd_addr = a;
        #1 d = reg_rd_data;
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        rd(W1_STAT, v); chk("R1 status", v, 0);
        rd(W1_FLAG, v); chk("R1 flag", v, 0);
        rd(F_EEN, v);   chk("R1 frame enable", v, 0);
        chk("R1 irq", DW'(irq_o), 0);
        chk("R1 req", DW'(acc_req_o), 0);
        rd(F_CFG, v);   chk("R9 config", v, 4);
        rd(F_ID, v);    chk("R9 id", v, 32'h21);
    endtask

    task automatic t_set();
        logic [DW-1:0] v;
        wr(W1_SET, 32'h5);
        wr(W1_SET, 32'h30);
        rd(W1_STAT, v); chk("R2 set accumulates", v, 32'h35);
        chk("R2 receiver view", win_stat_o[63:32], 32'h35);
        wr(W1_SET, 32'h0);
        rd(W1_STAT, v); chk("R2 zero set no effect", v, 32'h35);
        wr(W1_STAT, 32'hFFFF);
        rd(W1_STAT, v); chk("R11 status write ignored", v, 32'h35);
    endtask

    task automatic t_drain();
        logic [DW-1:0] v;
        wr(W1_FEN, 1);
        wr(F_EEN, 4);
        rclr(2'd1, 32'h05);
        rd(W1_FLAG, v); chk("R4 partial clear no flag", v, 0);
        rclr(2'd1, 32'h30);
        rd(W1_FLAG, v); chk("R4 drain sets flag", v, 1);
        chk("R6 irq on drain", DW'(irq_o), 1);
        rd(F_COMB, v);  chk("R5 combined bit", v, 32'h2);
        reg_rd_addr = W1_FLAG; #1 chk("R10 no flag rev0", rd_v0, 0);
        chk("R10 no irq rev0", DW'(irq_v0), 0);
        wr(W1_FCLR, 1);
        rd(W1_FLAG, v); chk("R4 flag cleared", v, 0);
        chk("R6 irq drops", DW'(irq_o), 0);
        wr(W1_FEN, 0);
        wr(W1_SET, 32'h8);
        rclr(2'd1, 32'hFFFF_FFFF);
        rd(W1_FLAG, v); chk("R5 flag without enable", v, 1);
        rd(F_COMB, v);  chk("R5 combined gated", v, 0);
        chk("R6 irq gated", DW'(irq_o), 0);
        wr(W1_FCLR, 1);
    endtask

    task automatic t_races();
        logic [DW-1:0] v;
        wr(W1_SET, 32'h1);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = W1_SET; reg_wr_data = 32'h1;
        rcv_clr_en = 1'b1; rcv_clr_win = 2'd1; rcv_clr_mask = 32'h1;
        @(negedge clk);
        reg_wr_en = 1'b0; rcv_clr_en = 1'b0;
        rd(W1_STAT, v); chk("R3 set beats clear", v, 32'h1);
        rd(W1_FLAG, v); chk("R3 no drain", v, 0);
        wr(W1_SET, 32'h4);
        rclr(2'd0, 32'hFFFF_FFFF);
        rd(W1_STAT, v); chk("R3 other window untouched", v, 32'h5);
        rclr(2'd1, 32'h1);
        rd(W1_STAT, v); chk("R3 masked clear", v, 32'h4);
        // drain and flag clear in the same cycle
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = W1_FCLR; reg_wr_data = 32'h1;
        rcv_clr_en = 1'b1; rcv_clr_win = 2'd1; rcv_clr_mask = 32'h4;
        @(negedge clk);
        reg_wr_en = 1'b0; rcv_clr_en = 1'b0;
        rd(W1_FLAG, v); chk("R4 drain beats clear", v, 1);
        wr(W1_FCLR, 1);
    endtask

    task automatic t_handshake();
        logic [DW-1:0] v;
        wr(F_REQ, 1);
        chk("R7 request out", DW'(acc_req_o), 1);
        rd(F_REQ, v); chk("R7 request reads", v, 1);
        @(negedge clk); rx_ready_i = 1'b1;
        @(negedge clk);
        rd(F_RDY, v); chk("R7 ready after one edge", v, 0);
        @(negedge clk);
        rd(F_RDY, v); chk("R7 ready after two edges", v, 1);
        rd(F_EVT, v); chk("R8 rise event", v, 32'h1);
        chk("R8 rise gated off", DW'(irq_o), 0);
        wr(F_EEN, 2);
        chk("R8 rise irq", DW'(irq_o), 1);
        wr(F_ECLR, 1);
        rd(F_EVT, v); chk("R8 event cleared", v, 0);
        chk("R8 irq drops", DW'(irq_o), 0);
        wr(F_EEN, 1);
        @(negedge clk); rx_ready_i = 1'b0;
        @(negedge clk); @(negedge clk);
        rd(F_RDY, v); chk("R7 ready falls", v, 0);
        rd(F_EVT, v); chk("R8 fall event", v, 32'h2);
        chk("R8 fall irq", DW'(irq_o), 1);
        wr(F_REQ, 0);
        chk("R7 request withdrawn", DW'(acc_req_o), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 act=%0d exp=0", checks);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set();
        t_drain();
        t_races();
        t_handshake();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule